// File: doc/BRIEF.md
# Sub-Nyquist Phase-Movement Detector

This block measures how far a fast square wave creeps in phase against an implied nominal rate, using a sampling clock that is much slower than the signal. The incoming signal first drives a toggle flop, which produces a half-rate square wave with an exact 50/50 duty cycle. That level is brought into the sampling clock domain through a two-flop synchroniser. The resulting sample stream is treated as N interleaved sub-streams: sample position k of every N-sample interval belongs to sub-stream k. Each new sample is XOR-compared with the sample taken exactly N positions earlier. A difference means that the signal has slipped by one whole cycle against the implied reference as seen by that sub-stream.

A per-stream enable mask selects which sub-streams count. Picking streams whose starting phases spread evenly over one signal cycle sets the resolution of the measurement. At the end of every N-sample interval, the block adds up the slips from the enabled streams and subtracts a signed offset. It then presents the signed result together with a one-cycle strobe. A digital integrator in a frequency-locked loop would consume this result.

The control is a two-state machine. ST_PRIME is entered at reset. It lasts N sampling cycles while the history register fills, and comparisons are ignored during that time. The transition PRIME_DONE is taken on the last phase slot and leads to ST_RUN. ST_RUN accumulates the masked comparisons and emits a result on every last phase slot (transition INTERVAL_END, a self-loop). Reset is the only way back to ST_PRIME.

Top module: `phase_slip_detector`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, `slip_valid_o` is 0 and `slip_o` is 0.
- R2: Every rising edge of `sig_i` toggles the half-rate level. An odd number of rising edges between two sampling edges inverts the next sample, and an even number leaves it unchanged.
- R3: The half-rate level present just before sampling edge t takes part in comparisons as the sample of edge t+2. Edge 0 is the first rising edge of `clk_i` after reset release. The samples of edges 0 to N-1 only fill history. The first strobe follows edge 2N-1.
- R4: The sample of edge t belongs to stream (t mod N). It counts as one slip when it differs from the sample of edge t-N.
- R5: A stream whose bit in `stream_mask_i` is 0 contributes nothing. With an all-zero mask, every result equals -`offset_i`.
- R6: Each result equals the number of slips over edges t-N+1 to t, minus the two's-complement `offset_i`, as a signed value with no overflow.
- R7: `slip_valid_o` is high for exactly one cycle after each edge t with t mod N = N-1 and t ≥ 2N-1, and low otherwise. `slip_o` holds its value between strobes.
- R8: A signal whose half-rate sample pattern repeats every N samples yields a result of -`offset_i` in every interval after the first.
- R9: The extreme offsets -2^(OFS_W-1) and 2^(OFS_W-1)-1 give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Fast square-wave signal under measurement |
| stream_mask_i | input | N | Sub-stream enable, bit k enables stream k |
| offset_i | input | OFS_W | Signed value subtracted from each interval count |
| slip_o | output | RES_W | Signed interval result |
| slip_valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
A phase counter or history register that is off by one would be seen at the ports within the first two intervals. Under randomly varying pulse counts, a misaligned stream or a wrong history depth changes the slip count at the first strobe. A stuck state machine shows up as a strobe that arrives early, late or not at all. Faults in the offset path or the sign extension would show in the first result with extreme offsets. A mask-decode fault would show in the first result with a single-bit or all-zero mask.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } psd_state_e;

    localparam int unsigned DEFAULT_SYNC_STAGES = 2;

endpackage

// File: rtl/psd_halver.sv
module psd_halver (
    input  logic sig_i,
    input  logic rst_ni,
    output logic half_o
);

    logic half_q;

    always_ff @(posedge sig_i or negedge rst_ni) begin
        if (!rst_ni) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    assign half_o = half_q;

endmodule

// File: rtl/psd_sync.sv
module psd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[0] <= 1'b0;
                    else         chain_q[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/psd_stream_cmp.sv
module psd_stream_cmp #(
    parameter int N  = 16,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sample_i,
    input  logic [PW-1:0] sel_i,
    input  logic [N-1:0]  mask_i,
    output logic          hit_o
);

    // hist_q[j] holds the sample from j+1 edges ago
    logic [N-1:0] hist_q;
    logic         differs;
    logic         enabled;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[N-2:0], sample_i};
        end
    end

    assign differs = sample_i ^ hist_q[N-1];
    assign enabled = mask_i[sel_i];
    assign hit_o   = differs & enabled;

endmodule

// File: rtl/psd_interval_ctrl.sv
module psd_interval_ctrl
    import psd_pkg::*;
#(
    parameter int N     = 16,
    parameter int OFS_W = 8,
    parameter int CNT_W = 5,
    parameter int RES_W = 9,
    localparam int PW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hit_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic [PW-1:0]    sel_o,
    output logic [RES_W-1:0] slip_o,
    output logic             slip_valid_o
);

    localparam logic [PW-1:0] LAST_SLOT = PW'(N - 1);

    psd_state_e state_q, state_d;
    logic [PW-1:0]    phase_q;
    logic [CNT_W-1:0] acc_q;
    logic [RES_W-1:0] slip_q;
    logic             valid_q;
    logic             last_slot;
    logic signed [RES_W-1:0] count_ext;
    logic signed [RES_W-1:0] offset_ext;
    logic signed [RES_W-1:0] total;

    assign last_slot = (phase_q == LAST_SLOT);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_PRIME;
        else         state_q <= state_d;
    end

    // transitions: PRIME_DONE and INTERVAL_END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (last_slot) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    // phase slot counter runs in both states
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        phase_q <= '0;
        else if (last_slot) phase_q <= '0;
        else                phase_q <= phase_q + PW'(1);
    end

    assign count_ext  = RES_W'(acc_q) + RES_W'(hit_i);
    assign offset_ext = RES_W'($signed(offset_i));
    assign total      = count_ext - offset_ext;

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q   <= '0;
            slip_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PRIME: begin
                    acc_q   <= '0;
                    valid_q <= 1'b0;
                end
                ST_RUN: begin
                    if (last_slot) begin
                        acc_q   <= '0;
                        slip_q  <= total;
                        valid_q <= 1'b1;
                    end else begin
                        acc_q   <= acc_q + CNT_W'(hit_i);
                        valid_q <= 1'b0;
                    end
                end
                default: begin
                    acc_q   <= '0;
                    valid_q <= 1'b0;
                end
            endcase
        end
    end

    assign sel_o        = phase_q;
    assign slip_o       = slip_q;
    assign slip_valid_o = valid_q;

endmodule

// File: rtl/phase_slip_detector.sv
module phase_slip_detector #(
    parameter int N           = 16,
    parameter int OFS_W       = 8,
    parameter int SYNC_STAGES = psd_pkg::DEFAULT_SYNC_STAGES,
    localparam int CNT_W      = $clog2(N + 1),
    localparam int RES_W      = ((OFS_W > CNT_W) ? OFS_W : CNT_W) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sig_i,
    input  logic [N-1:0]     stream_mask_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic [RES_W-1:0] slip_o,
    output logic             slip_valid_o
);

    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic          half_lvl;
    logic          sample;
    logic          hit;
    logic [PW-1:0] sel;

    psd_halver u_halver (
        .sig_i  (sig_i),
        .rst_ni (rst_ni),
        .half_o (half_lvl)
    );

    psd_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (half_lvl),
        .q_o    (sample)
    );

    psd_stream_cmp #(
        .N (N)
    ) u_cmp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (sample),
        .sel_i    (sel),
        .mask_i   (stream_mask_i),
        .hit_o    (hit)
    );

    psd_interval_ctrl #(
        .N     (N),
        .OFS_W (OFS_W),
        .CNT_W (CNT_W),
        .RES_W (RES_W)
    ) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .hit_i        (hit),
        .offset_i     (offset_i),
        .sel_o        (sel),
        .slip_o       (slip_o),
        .slip_valid_o (slip_valid_o)
    );

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int N     = 16,
    parameter int OFS_W = 8,
    parameter int RES_W = 9
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [OFS_W-1:0] offset_i,
    input logic [RES_W-1:0] slip_o,
    input logic             slip_valid_o
);

    localparam int TW = $clog2(2 * N + 2) + 1;

    logic [TW-1:0] since_q;
    logic [TW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q <= '0;
            gap_q   <= '0;
            seen_q  <= 1'b0;
        end else begin
            if (since_q < TW'(2 * N + 1)) since_q <= since_q + TW'(1);
            if (slip_valid_o) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q < TW'(2 * N)) begin
                gap_q <= gap_q + TW'(1);
            end
        end
    end

    // R7
    strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slip_valid_o |=> !slip_valid_o);

    // R7
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slip_valid_o |-> $stable(slip_o));

    // R7
    strobe_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slip_valid_o && seen_q) |-> (gap_q == TW'(N - 1)));

    // R3
    first_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slip_valid_o && !seen_q) |-> (since_q == TW'(2 * N)));

    // R6
    result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slip_valid_o |->
            ((int'($signed(slip_o)) + int'($signed($past(offset_i)))) >= 0 &&
             (int'($signed(slip_o)) + int'($signed($past(offset_i)))) <= N));

    // R1
    quiet_before_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!seen_q && !slip_valid_o) |-> (slip_o == '0));

endmodule

bind phase_slip_detector psd_checker #(
    .N     (N),
    .OFS_W (OFS_W),
    .RES_W (RES_W)
) u_psd_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .offset_i     (offset_i),
    .slip_o       (slip_o),
    .slip_valid_o (slip_valid_o)
);

// File: tb/test_phase_slip_detector.sv
module test_phase_slip_detector;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int OFS_W      = 8;
    localparam int RES_W      = 9;
    localparam int MAXT       = N * 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig = 1'b0;
    logic [N-1:0]     mask = '0;
    logic [OFS_W-1:0] offset = '0;
    logic [RES_W-1:0] slip;
    logic             slip_valid;

    int checks = 0;
    int fails  = 0;
    bit h_model = 1'b0;
    bit hq[MAXT];
    bit q2[MAXT];

    always #(CLK_PERIOD / 2) clk = ~clk;

    phase_slip_detector #(
        .N     (N),
        .OFS_W (OFS_W)
    ) i_phase_slip_detector (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .sig_i         (sig),
        .stream_mask_i (mask),
        .offset_i      (offset),
        .slip_o        (slip),
        .slip_valid_o  (slip_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expected_result(input int t, input logic [N-1:0] m, input int off);
        int hits = 0;
        for (int s = t - N + 1; s <= t; s++) begin
            if (m[s % N] && (q2[s] != q2[s - N])) hits++;
        end
        return hits - off;
    endfunction

    // mode 0: pattern repeating every N samples, 1: random pulse counts,
    // 2: repeating pattern plus one extra pulse per interval
    task automatic run_seg(input logic [N-1:0] m, input int off, input int mode,
                           input int nint, input string tag);
        int ptab[N];
        int par = 0;
        int tend;
        for (int k = 0; k < N; k++) begin
            ptab[k] = int'($urandom % 3);
            par += ptab[k];
        end
        if (par % 2 == 1) ptab[N-1] = (ptab[N-1] == 2) ? 1 : ptab[N-1] + 1;

        rst_n   = 1'b0;
        mask    = m;
        offset  = off[OFS_W-1:0];
        sig     = 1'b0;
        h_model = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(slip_valid == 1'b0, "R1 strobe in reset", int'(slip_valid), 0);
        chk(slip == '0, "R1 result in reset", int'($signed(slip)), 0);
        @(negedge clk);
        rst_n = 1'b1;

        tend = (nint + 1) * N;
        for (int t = 0; t < tend; t++) begin
            int p;
            bit exp_v;
            @(posedge clk);
            hq[t] = h_model;
            q2[t] = (t >= 2) ? hq[t-2] : 1'b0;
            #1;
            unique case (mode)
                0:       p = ptab[t % N];
                1:       p = int'($urandom % 4);
                default: p = ptab[t % N] + ((t % N == 3) ? 1 : 0);
            endcase
            for (int i = 0; i < p; i++) begin
                sig = 1'b1;
                #1;
                sig = 1'b0;
                #1;
                h_model = ~h_model;
            end
            #(7 - 2 * p);
            exp_v = (t >= 2 * N - 1) && (t % N == N - 1);
            if (t < 2 * N - 1) begin
                chk(slip_valid == 1'b0, "R3 no early strobe", int'(slip_valid), 0);
                chk(slip == '0, "R1 result before first strobe", int'($signed(slip)), 0);
            end else begin
                chk(slip_valid == exp_v, "R7 strobe timing", int'(slip_valid), int'(exp_v));
            end
            if (exp_v) begin
                int ev = expected_result(t, m, off);
                chk(int'($signed(slip)) == ev, tag, int'($signed(slip)), ev);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        // R8 repeating pattern, partial and full masks
        run_seg(16'h5555, 0, 0, 4, "R8 nominal");
        run_seg('1, 5, 0, 4, "R8 nominal offset");
        // R2 random odd/even pulse counts, full mask
        run_seg('1, 0, 1, 4, "R2 random pulses");
        // R5 all streams disabled
        run_seg('0, 37, 1, 3, "R5 zero mask");
        // R4 single stream
        run_seg(16'h0008, 0, 1, 4, "R4 single stream");
        run_seg(16'h8001, -3, 1, 4, "R4 edge streams");
        // R6 repeating pattern with injected slip
        run_seg('1, 1, 2, 4, "R6 injected slip");
        // R9 extreme offsets
        run_seg('1, -128, 1, 3, "R9 min offset");
        run_seg('1, 127, 1, 3, "R9 max offset");
        // R6 random mixes
        for (int r = 0; r < 5; r++) begin
            logic [N-1:0] rm;
            rm = N'($urandom);
            run_seg(rm, int'($urandom % 256) - 128, 1, 3, "R6 random mix");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule